// File: doc/BRIEF.md
# 3D Voxel Line Rasterizer

This block draws into a cubic voxel frame buffer of 8-bit intensities. A host programs two endpoint coordinates and a colour through a small byte-wide register file, then writes a command byte. The engine either plots one voxel at the first point, or walks an integer 3D Bresenham line from the first point to the second. It plots one voxel per clock through a write port (strobe, linear address, data) that feeds the video memory.

While a command runs, a busy flag in the status register is set, and further command writes are dropped. Voxels whose coordinates fall outside the cube are skipped, but the walk still spends a cycle on them. The host polls the busy flag before it issues the next command.

Top module: `voxel_line_engine`

## Requirements
- R1: After reset, status reads 0 (not busy), no voxel write is issued, and every stored register reads 0.
- R2: The register addresses are 0 = point-1 position, 1 = point-1 depth, 2 = point-2 position, 3 = point-2 depth, 4 = colour, 5 = command (reads 0), 6 = status. Each position register holds x in bits 7:4 and y in bits 3:0. Each depth register holds z in bits 7:4, and its bits 3:0 have no effect on drawing. Registers 0 to 4 read back what was written.
- R3: Command code 1 plots exactly one voxel at point 1, with data equal to the colour register and address x*100 + y*10 + z. Busy is high for exactly one cycle, starting on the cycle after the command write.
- R4: Command code 2 emits max(|dx|,|dy|,|dz|)+1 voxel steps. The first step is point 1, the last step is point 2, and busy is high for exactly that many cycles.
- R5: On each line step, the axis with the largest delta moves by one. Every other axis moves by one when its error term, which starts at 2*d - dmax and adds 2*d each step, is non-negative before the step; in that case 2*dmax is subtracted from the term.
- R6: A step with any coordinate of 10 or more issues no write but still takes its cycle. Every issued address is below 1000.
- R7: Code 0 does nothing and busy stays low. Code 3 and every code from 4 to 255 hold busy for one cycle and write nothing.
- R8: A command write while busy is set has no effect: the running command's writes and busy length are unchanged.
- R9: At most one voxel write is issued per clock, and only while busy is set.
- R10: Status bit 0 is the busy flag, and bits 7:1 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for regAddr |
| pixWe | output | 1 | Voxel write strobe |
| pixAddr | output | 10 | Linear voxel address |
| pixData | output | 8 | Voxel intensity |

## Verification
The bench builds the engine with its default parameters: 10 voxels per axis and 4-bit coordinate fields. With these values, coordinates 10 to 15 can be written, so lines that leave the cube are reachable. Deltas of up to 15 are also reachable, giving walks of 16 steps. Directed lines cover diagonals, reversed directions, tied deltas and zero-length lines. These are mixed with seeded random endpoints, and each line is checked step by step against a bench-side Bresenham model.

// File: rtl/vle_pkg.sv
package vle_pkg;

  // Register addresses seen by the host
  localparam int unsigned RA_P1_POS   = 0;
  localparam int unsigned RA_P1_DEPTH = 1;
  localparam int unsigned RA_P2_POS   = 2;
  localparam int unsigned RA_P2_DEPTH = 3;
  localparam int unsigned RA_COLOUR   = 4;
  localparam int unsigned RA_CMD      = 5;
  localparam int unsigned RA_STATUS   = 6;

  // Command codes
  localparam int unsigned OP_NONE  = 0;
  localparam int unsigned OP_POINT = 1;
  localparam int unsigned OP_LINE  = 2;

  // Control to datapath strobes
  typedef struct packed {
    logic start;     // load walk state from the endpoint registers
    logic lineMode;  // walk to point 2 (else a single step)
    logic plot;      // steps of this command produce writes
    logic advance;   // a step is consumed this cycle (busy)
  } vle_ctl_t;

endpackage

// File: rtl/vle_ctrl.sv
module vle_ctrl
  import vle_pkg::*;
#(
  parameter int REG_AW  = 3,
  parameter int DATA_W  = 8,
  parameter int COORD_W = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWr,
  input  logic [REG_AW-1:0]            regAddr,
  input  logic [DATA_W-1:0]            regWdata,
  output logic [DATA_W-1:0]            regRdata,
  input  logic                         done,
  output vle_ctl_t                     ctl,
  output logic [2:0][COORD_W-1:0]      p1,
  output logic [2:0][COORD_W-1:0]      p2,
  output logic [DATA_W-1:0]            colour
);

  logic [DATA_W-1:0] p1Pos, p1Dep, p2Pos, p2Dep, colourQ;
  logic busyQ, plotQ;
  logic cmdHit, startCmd;

  function automatic logic isAddr(input logic [REG_AW-1:0] a, input int unsigned v);
    return a == REG_AW'(v);
  endfunction

  assign cmdHit   = regWr && isAddr(regAddr, RA_CMD) && !busyQ;
  assign startCmd = cmdHit && (regWdata != DATA_W'(OP_NONE));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      p1Pos   <= '0;
      p1Dep   <= '0;
      p2Pos   <= '0;
      p2Dep   <= '0;
      colourQ <= '0;
    end else if (regWr) begin
      if (isAddr(regAddr, RA_P1_POS))   p1Pos   <= regWdata;
      if (isAddr(regAddr, RA_P1_DEPTH)) p1Dep   <= regWdata;
      if (isAddr(regAddr, RA_P2_POS))   p2Pos   <= regWdata;
      if (isAddr(regAddr, RA_P2_DEPTH)) p2Dep   <= regWdata;
      if (isAddr(regAddr, RA_COLOUR))   colourQ <= regWdata;
    end
  end

  // Busy sequencing: one command at a time
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      plotQ <= 1'b0;
    end else if (startCmd) begin
      busyQ <= 1'b1;
      plotQ <= (regWdata == DATA_W'(OP_POINT)) || (regWdata == DATA_W'(OP_LINE));
    end else if (busyQ && done) begin
      busyQ <= 1'b0;
      plotQ <= 1'b0;
    end
  end

  always_comb begin
    ctl.start    = startCmd;
    ctl.lineMode = (regWdata == DATA_W'(OP_LINE));
    ctl.plot     = busyQ && plotQ;
    ctl.advance  = busyQ;
  end

  assign p1[0] = p1Pos[2*COORD_W-1:COORD_W];
  assign p1[1] = p1Pos[COORD_W-1:0];
  assign p1[2] = p1Dep[DATA_W-1 -: COORD_W];
  assign p2[0] = p2Pos[2*COORD_W-1:COORD_W];
  assign p2[1] = p2Pos[COORD_W-1:0];
  assign p2[2] = p2Dep[DATA_W-1 -: COORD_W];
  assign colour = colourQ;

  always_comb begin
    regRdata = '0;
    if (isAddr(regAddr, RA_P1_POS))   regRdata = p1Pos;
    if (isAddr(regAddr, RA_P1_DEPTH)) regRdata = p1Dep;
    if (isAddr(regAddr, RA_P2_POS))   regRdata = p2Pos;
    if (isAddr(regAddr, RA_P2_DEPTH)) regRdata = p2Dep;
    if (isAddr(regAddr, RA_COLOUR))   regRdata = colourQ;
    if (isAddr(regAddr, RA_STATUS))   regRdata = {{(DATA_W-1){1'b0}}, busyQ};
  end

endmodule

// File: rtl/vle_datapath.sv
module vle_datapath
  import vle_pkg::*;
#(
  parameter int AXIS_N  = 10,
  parameter int COORD_W = 4,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  vle_ctl_t                ctl,
  input  logic [2:0][COORD_W-1:0] pA,
  input  logic [2:0][COORD_W-1:0] pB,
  input  logic [DATA_W-1:0]       colourIn,
  output logic                    done,
  output logic                    pixWe,
  output logic [ADDR_W-1:0]       pixAddr,
  output logic [DATA_W-1:0]       pixData
);

  localparam int ERR_W    = COORD_W + 3;
  localparam int STRIDE_X = AXIS_N * AXIS_N;

  logic [COORD_W-1:0]        delta   [3];
  logic                      negDir  [3];
  logic [COORD_W-1:0]        cur     [3];
  logic                      dirQ    [3];
  logic signed [ERR_W-1:0]   err     [3];
  logic signed [ERR_W-1:0]   incKeep [3];
  logic signed [ERR_W-1:0]   incMove [3];
  logic [COORD_W-1:0]        dMax;
  logic [COORD_W-1:0]        remaining;
  logic [DATA_W-1:0]         colourQ;

  function automatic logic signed [ERR_W-1:0] widen(input logic [COORD_W-1:0] v);
    return $signed({{(ERR_W-COORD_W){1'b0}}, v});
  endfunction

  always_comb begin
    dMax = '0;
    for (int a = 0; a < 3; a++)
      if (delta[a] > dMax) dMax = delta[a];
  end

  for (genvar a = 0; a < 3; a++) begin : g_axis
    assign negDir[a] = pB[a] < pA[a];
    assign delta[a]  = negDir[a] ? pA[a] - pB[a] : pB[a] - pA[a];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cur[a]     <= '0;
        dirQ[a]    <= 1'b0;
        err[a]     <= '0;
        incKeep[a] <= '0;
        incMove[a] <= '0;
      end else if (ctl.start) begin
        cur[a]     <= pA[a];
        dirQ[a]    <= negDir[a];
        err[a]     <= widen(delta[a]) + widen(delta[a]) - widen(dMax);
        incKeep[a] <= widen(delta[a]) + widen(delta[a]);
        incMove[a] <= widen(delta[a]) + widen(delta[a]) - widen(dMax) - widen(dMax);
      end else if (ctl.advance) begin
        if (!err[a][ERR_W-1]) begin
          cur[a] <= dirQ[a] ? cur[a] - COORD_W'(1) : cur[a] + COORD_W'(1);
          err[a] <= err[a] + incMove[a];
        end else begin
          err[a] <= err[a] + incKeep[a];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remaining <= '0;
      colourQ   <= '0;
    end else if (ctl.start) begin
      remaining <= ctl.lineMode ? dMax : '0;
      colourQ   <= colourIn;
    end else if (ctl.advance && remaining != '0) begin
      remaining <= remaining - COORD_W'(1);
    end
  end

  assign done = (remaining == '0);

  logic inCube;
  always_comb begin
    inCube = 1'b1;
    for (int a = 0; a < 3; a++)
      if ({1'b0, cur[a]} >= (COORD_W+1)'(AXIS_N)) inCube = 1'b0;
  end

  assign pixWe   = ctl.plot && inCube;
  assign pixAddr = inCube ? ADDR_W'(cur[0]) * ADDR_W'(STRIDE_X)
                          + ADDR_W'(cur[1]) * ADDR_W'(AXIS_N)
                          + ADDR_W'(cur[2])
                          : '0;
  assign pixData = colourQ;

endmodule

// File: rtl/voxel_line_engine.sv
module voxel_line_engine
  import vle_pkg::*;
#(
  parameter int AXIS_N  = 10,
  parameter int COORD_W = 4,
  parameter int DATA_W  = 8,
  parameter int REG_AW  = 3,
  localparam int ADDR_W = $clog2(AXIS_N * AXIS_N * AXIS_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              pixWe,
  output logic [ADDR_W-1:0] pixAddr,
  output logic [DATA_W-1:0] pixData
);

  vle_ctl_t                ctl;
  logic                    done;
  logic                    busy;
  logic [2:0][COORD_W-1:0] p1, p2;
  logic [DATA_W-1:0]       colour;

  vle_ctrl #(.REG_AW(REG_AW), .DATA_W(DATA_W), .COORD_W(COORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .done(done), .ctl(ctl),
    .p1(p1), .p2(p2), .colour(colour)
  );

  vle_datapath #(.AXIS_N(AXIS_N), .COORD_W(COORD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pA(p1), .pB(p2), .colourIn(colour),
    .done(done), .pixWe(pixWe), .pixAddr(pixAddr), .pixData(pixData)
  );

  assign busy = ctl.advance;

endmodule

// File: rtl/vle_checker.sv
module vle_checker #(
  parameter int AXIS_N = 10,
  parameter int DATA_W = 8,
  parameter int REG_AW = 3,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic [REG_AW-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              pixWe,
  input logic [ADDR_W-1:0] pixAddr,
  input logic              busy
);

  localparam int VOX_N = AXIS_N * AXIS_N * AXIS_N;

  // R9: writes only while a command runs
  p_we_in_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    pixWe |-> busy);

  // R6: issued addresses stay inside the cube
  p_addr_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    pixWe |-> (int'(pixAddr) < VOX_N));

  // R10: status layout
  p_status_pad_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == REG_AW'(6)) |-> (regRdata == {{(DATA_W-1){1'b0}}, busy}));

  // R3: an accepted non-zero command raises busy next cycle
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == REG_AW'(5) && regWdata != '0 && !busy) |=> busy);

  // R7: the no-operation code leaves the engine idle
  p_nop_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == REG_AW'(5) && regWdata == '0 && !busy) |=> !busy);

endmodule

bind voxel_line_engine vle_checker #(
  .AXIS_N(AXIS_N), .DATA_W(DATA_W), .REG_AW(REG_AW), .ADDR_W(ADDR_W)
) u_vle_checker (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
  .regWdata(regWdata), .regRdata(regRdata), .pixWe(pixWe),
  .pixAddr(pixAddr), .busy(busy)
);

// File: tb/voxel_line_engine_bench.sv
module voxel_line_engine_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [2:0] regAddr = 3'd6;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       pixWe;
  logic [9:0] pixAddr;
  logic [7:0] pixData;

  voxel_line_engine u_voxel_line_engine (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pixWe(pixWe),
    .pixAddr(pixAddr), .pixData(pixData)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cycleCount = 0;

  // captured writes
  int gotN = 0;
  int gotAddr [64];
  int gotData [64];
  // expected
  int expN;
  int expSteps;
  int expAddr [32];

  always @(negedge clk) begin
    cycleCount++;
    if (pixWe && gotN < 64) begin
      gotAddr[gotN] = int'(pixAddr);
      gotData[gotN] = int'(pixData);
      gotN++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Bench model of the line walk from the requirement text
  function automatic void model(input int a0, a1, a2, input int b0, b1, b2, input bit line);
    int c [3]; int b [3]; int d [3]; int s [3]; int e [3];
    int dm, k;
    c[0]=a0; c[1]=a1; c[2]=a2; b[0]=b0; b[1]=b1; b[2]=b2;
    dm = 0; k = 0;
    for (int i = 0; i < 3; i++) begin
      d[i] = (b[i] > c[i]) ? b[i]-c[i] : c[i]-b[i];
      s[i] = (b[i] < c[i]) ? -1 : 1;
      if (d[i] > dm) begin dm = d[i]; k = i; end
    end
    if (!line) dm = 0;
    for (int i = 0; i < 3; i++) e[i] = 2*d[i] - dm;
    expN = 0;
    expSteps = dm + 1;
    for (int st = 0; st <= dm; st++) begin
      if (c[0] < 10 && c[1] < 10 && c[2] < 10) begin
        expAddr[expN] = c[0]*100 + c[1]*10 + c[2];
        expN++;
      end
      if (st < dm) begin
        for (int i = 0; i < 3; i++) begin
          if (i == k) c[i] += s[i];
          else begin
            if (e[i] >= 0) begin c[i] += s[i]; e[i] -= 2*dm; end
            e[i] += 2*d[i];
          end
        end
      end
    end
  endfunction

  task automatic wr(input int a, input int v);
    @(negedge clk);
    regWr = 1'b1; regAddr = 3'(a); regWdata = 8'(v);
    @(negedge clk);
    regWr = 1'b0; regAddr = 3'd6;
  endtask

  task automatic setPoints(input int a0, a1, a2, input int b0, b1, b2, input int col, input int lowJunk);
    wr(0, a0*16 + a1);
    wr(1, a2*16 + lowJunk);
    wr(2, b0*16 + b1);
    wr(3, b2*16 + lowJunk);
    wr(4, col);
  endtask

  // issue a command and count busy cycles; injectAt>0 writes a command mid-run
  task automatic run(input int code, input int injectAt, output int busyCycles);
    @(negedge clk);
    gotN = 0;
    regWr = 1'b1; regAddr = 3'd5; regWdata = 8'(code);
    @(negedge clk);
    regWr = 1'b0; regAddr = 3'd6;
    busyCycles = 0;
    while (busyCycles < 100) begin
      #1;
      if (!regRdata[0]) break;
      busyCycles++;
      if (busyCycles == injectAt) begin
        regWr = 1'b1; regAddr = 3'd5; regWdata = 8'd1;
      end
      @(negedge clk);
      regWr = 1'b0; regAddr = 3'd6;
    end
  endtask

  task automatic lineCase(input string tag, input int a0, a1, a2, input int b0, b1, b2,
                          input int col, input bit line, input int injectAt);
    int bc;
    bit allOk;
    setPoints(a0, a1, a2, b0, b1, b2, col, 4'hB);
    model(a0, a1, a2, b0, b1, b2, line);
    run(line ? 2 : 1, injectAt, bc);
    check(bc == expSteps, {tag, " busy length R4"}, bc, expSteps);
    check(gotN == expN, {tag, " write count R6"}, gotN, expN);
    allOk = 1'b1;
    for (int i = 0; i < expN && i < gotN; i++) begin
      if (gotAddr[i] != expAddr[i]) begin
        allOk = 1'b0;
        $display("FAIL %s R5 step %0d actual=%0d expected=%0d", tag, i, gotAddr[i], expAddr[i]);
      end
      if (gotData[i] != col) begin
        allOk = 1'b0;
        $display("FAIL %s R3 colour actual=%0d expected=%0d", tag, gotData[i], col);
      end
    end
    checks++;
    if (!allOk) failures++;
  endtask

  initial begin
    int bc;
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check(regRdata == 8'd0, "R1 status after reset", int'(regRdata), 0);
    check(pixWe == 1'b0, "R1 no write in reset", int'(pixWe), 0);
    @(negedge clk);
    rstN = 1'b1;
    regAddr = 3'd0;
    #1;
    check(regRdata == 8'd0, "R1 register cleared", int'(regRdata), 0);

    // R2: readback and depth low bits ignored
    wr(0, 8'hA7);
    regAddr = 3'd0; #1;
    check(regRdata == 8'hA7, "R2 readback", int'(regRdata), 8'hA7);
    regAddr = 3'd5; #1;
    check(regRdata == 8'h00, "R2 command reads 0", int'(regRdata), 0);
    regAddr = 3'd6;

    // R3: single voxel at x=3 y=7 z=5, depth low bits set
    lineCase("R3 voxel", 3, 7, 5, 9, 0, 0, 8'h5C, 1'b0, 0);
    check(gotN == 1 && gotAddr[0] == 375, "R3 voxel address", gotAddr[0], 375);

    // R4/R5 directed lines
    lineCase("R4 diagonal", 0, 0, 0, 9, 9, 9, 8'h11, 1'b1, 0);
    lineCase("R5 shallow", 0, 0, 0, 9, 3, 1, 8'h22, 1'b1, 0);
    lineCase("R5 reversed", 9, 2, 8, 1, 5, 0, 8'h33, 1'b1, 0);
    lineCase("R5 tie", 2, 2, 2, 6, 6, 0, 8'h44, 1'b1, 0);
    lineCase("R4 zero length", 4, 4, 4, 4, 4, 4, 8'h55, 1'b1, 0);
    check(gotN == 1 && gotAddr[0] == 444, "R4 zero length endpoint", gotAddr[0], 444);

    // R6: line leaving the cube
    lineCase("R6 clipped", 8, 0, 0, 13, 2, 1, 8'h66, 1'b1, 0);
    lineCase("R6 voxel outside", 12, 1, 1, 0, 0, 0, 8'h67, 1'b0, 0);

    // R7: other codes
    run(3, 0, bc);
    check(bc == 1, "R7 code 3 busy", bc, 1);
    check(gotN == 0, "R7 code 3 no write", gotN, 0);
    run(200, 0, bc);
    check(bc == 1 && gotN == 0, "R7 code 200", bc*100 + gotN, 100);
    run(0, 0, bc);
    check(bc == 0 && gotN == 0, "R7 code 0", bc*100 + gotN, 0);

    // R8: command write during a run
    lineCase("R8 ignored", 0, 9, 0, 9, 0, 5, 8'h77, 1'b1, 3);

    // R9 via random lines (count per step), some outside the cube
    for (int n = 0; n < 40; n++) begin
      int lim;
      lim = (n % 5 == 4) ? 16 : 10;
      lineCase("R9 random", int'($urandom % lim), int'($urandom % lim), int'($urandom % lim),
               int'($urandom % lim), int'($urandom % lim), int'($urandom % lim),
               int'($urandom % 256), 1'b1, 0);
    end

    // R10: status pad bits
    regAddr = 3'd6; #1;
    check(regRdata == 8'd0, "R10 status idle", int'(regRdata), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycleCount > 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycleCount, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule